// File: doc/BRIEF.md
# Left-Justified Stereo Serial Audio Receiver

This block takes stereo audio from an external transmitter over a three-wire left-justified serial link and hands each completed left/right pair to a downstream output stage. It is always a slave. The bit clock, the frame sync and the serial data line are all inputs, and the block creates no clock of its own. The frame sync is high for the left channel and low for the right channel. It changes in the same bit period as the first bit of each channel, with no one-bit delay. Each channel carries a 16-bit sample, most significant bit first.

All three serial inputs are oversampled in the system clock domain through a two-flop synchronizer. A bit is taken when the synchronized bit clock falls, because the transmitter moves data on the rising edge. Each bit-clock phase, high and low, must last at least two system clock cycles.

A completed pair is offered on a valid/ready output. The serial source cannot be stalled, so back-pressure never reaches it. A pair that has not been accepted is replaced by the next completed pair. A frame-sync edge that arrives before 16 bits have been collected discards the partial sample and sets a sticky framing-error flag.

Top module: `lj_audio_rx`

## Requirements
- R1: After reset, out_valid and frame_err are both 0.
- R2: The 16 bits sampled on the bit-clock falling edges that follow a rising edge of the frame sync form out_left, with the first bit received as bit 15.
- R3: The 16 bits that follow a falling edge of the frame sync form out_right, with the first bit as bit 15. When the 16th right bit arrives and the left sample of the same frame was complete, the pair is offered with out_valid = 1.
- R4: Bits beyond the 16th in a channel slot, such as in 32-bit slots, are ignored and leave the delivered sample unchanged.
- R5: A frame-sync edge after fewer than 16 bits in the current channel sets frame_err, and no pair is delivered for that frame.
- R6: frame_err stays 1 until reset, and later good frames are still delivered.
- R7: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_left/out_right hold steady unless a newer pair completes, which replaces the held one. A pair is consumed on a cycle where out_valid and out_ready are both 1.
- R8: Reception starts only at the first rising frame-sync edge seen after reset that was preceded by a low frame sync. Bits received before that edge deliver no pair and set no error.
- R9: out_valid rises no later than 6 system clock cycles after the bit-clock falling edge that carries the last right-channel bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bclk | input | 1 | Serial bit clock from the transmitter |
| ser_fsync | input | 1 | Frame sync: 1 = left channel, 0 = right channel |
| ser_data | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | A left/right pair is offered |
| out_ready | input | 1 | Downstream accepts the offered pair |
| out_left | output | 16 | Left sample |
| out_right | output | 16 | Right sample |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
A bit counter that drifts, or a channel tracker that locks onto the wrong frame-sync level, shows up at the ports as shifted or swapped sample words on the first pair delivered after the fault. It can also show up as a pair that is missing entirely or as an extra pair. A stale pair held in the output register shows up as a duplicate, or as a value that changes while out_ready is low. Any error in the error logic appears within one frame as a wrong frame_err level. Pipeline timing faults show up as a late out_valid, measured against the falling edge of the last right bit.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;
  localparam int DEF_SAMPLE_W    = 16;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } lj_chan_e;
endpackage

// File: rtl/lj_rx_sync.sv
module lj_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/lj_rx_bitstb.sv
module lj_rx_bitstb (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  output logic bit_stb
);
  logic bclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_s;
  end

  assign bit_stb = bclk_d & ~bclk_s;

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/lj_rx_deser.sv
module lj_rx_deser
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb,
  input  logic                fs_s,
  input  logic                sd_s,
  output logic                pair_stb,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r,
  output logic                frm_err
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] next_word;
  lj_chan_e            chan_last;
  logic                locked;
  logic                left_ok;

  assign next_word = {shreg[SAMPLE_W-2:0], sd_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      chan_last <= CH_LEFT;
      locked    <= 1'b0;
      left_ok   <= 1'b0;
      pair_l    <= '0;
      pair_r    <= '0;
      pair_stb  <= 1'b0;
      frm_err   <= 1'b0;
    end else begin
      pair_stb <= 1'b0;
      if (bit_stb) begin
        if (lj_chan_e'(fs_s) != chan_last) begin
          chan_last <= lj_chan_e'(fs_s);
          cnt       <= CNT_W'(1);
          shreg     <= {{(SAMPLE_W-1){1'b0}}, sd_s};
          if (locked && cnt != CNT_FULL) frm_err <= 1'b1;
          if (fs_s) begin
            locked  <= 1'b1;
            left_ok <= 1'b0;
          end
        end else if (cnt != CNT_FULL) begin
          cnt   <= cnt + CNT_W'(1);
          shreg <= next_word;
          if (cnt == CNT_LAST) begin
            if (chan_last == CH_LEFT) begin
              pair_l  <= next_word;
              left_ok <= locked;
            end else if (left_ok) begin
              pair_r   <= next_word;
              pair_stb <= 1'b1;
              left_ok  <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> frm_err);

  // R3
  emit_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> $past(bit_stb));

  // R8
  locked_before_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> locked);
endmodule

// File: rtl/lj_rx_hold.sv
module lj_rx_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_stb,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else if (in_stb) begin
      out_valid <= 1'b1;
      out_l     <= in_l;
      out_r     <= in_r;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_stb) |=> (out_valid && $stable(out_l) && $stable(out_r)));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> (out_valid && out_l == $past(in_l) && out_r == $past(in_r)));
endmodule

// File: rtl/lj_audio_rx.sv
module lj_audio_rx
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W    = DEF_SAMPLE_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_bclk,
  input  logic                ser_fsync,
  input  logic                ser_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                frame_err
);
  localparam int SER_W = 3;

  logic [SER_W-1:0]    ser_s;
  logic                bit_stb;
  logic                pair_stb;
  logic [SAMPLE_W-1:0] pair_l;
  logic [SAMPLE_W-1:0] pair_r;

  lj_rx_sync #(.WIDTH(SER_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ser_bclk, ser_fsync, ser_data}),
    .d_sync  (ser_s)
  );

  lj_rx_bitstb u_bitstb (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_s  (ser_s[2]),
    .bit_stb (bit_stb)
  );

  lj_rx_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb  (bit_stb),
    .fs_s     (ser_s[1]),
    .sd_s     (ser_s[0]),
    .pair_stb (pair_stb),
    .pair_l   (pair_l),
    .pair_r   (pair_r),
    .frm_err  (frame_err)
  );

  lj_rx_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stb    (pair_stb),
    .in_l      (pair_l),
    .in_r      (pair_r),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_l     (out_left),
    .out_r     (out_right)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !frame_err));
endmodule

// File: tb/test_lj_audio_rx.sv
module test_lj_audio_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_bclk = 1'b0;
  logic        ser_fsync = 1'b1;
  logic        ser_data = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_left;
  logic [15:0] out_right;
  logic        frame_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_last = 0;
  bit lat_en = 1'b1;
  bit done = 1'b0;

  logic [31:0] exp_q [64];
  logic [31:0] rx_q [64];
  int exp_n = 0;
  int rx_n = 0;

  always #10 clk = ~clk;

  lj_audio_rx i_lj_audio_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_bclk  (ser_bclk),
    .ser_fsync (ser_fsync),
    .ser_data  (ser_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_left  (out_left),
    .out_right (out_right),
    .frame_err (frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rx_n < 64) rx_q[rx_n] = {out_left, out_right};
      rx_n++;
      if (lat_en) chk("R9 latency", 32'(cyc - t_last <= 6), 32'd1);
    end
  end

  function automatic logic [31:0] pack_pair(input logic [15:0] l, input logic [15:0] r);
    return {l, r};
  endfunction

  task automatic drive_bit(input logic fs, input logic b, input bit mark);
    @(negedge clk);
    ser_bclk = 1'b1; ser_fsync = fs; ser_data = b;
    repeat (4) @(negedge clk);
    ser_bclk = 1'b0;
    if (mark) t_last = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic fs, input logic [15:0] val, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? val[15-i] : logic'($urandom % 2);
      drive_bit(fs, b, (fs == 1'b0) && (i == 15));
    end
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                            input int nl, input int nr, input bit push);
    send_slot(1'b1, l, nl);
    send_slot(1'b0, r, nr);
    if (push && nl >= 16 && nr >= 16) begin
      exp_q[exp_n] = pack_pair(l, r);
      exp_n++;
    end
  endtask

  task automatic check_rx(input string req);
    repeat (12) @(negedge clk);
    chk({req, " pair count"}, 32'(rx_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < rx_n && i < 64; i++)
      chk({req, " pair data"}, rx_q[i], exp_q[i]);
    rx_n = 0;
    exp_n = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 err in reset", 32'(frame_err), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 32'd0);
    chk("R1 err after reset", 32'(frame_err), 32'd0);

    // R8: tail of a left slot already under way at reset, then a right slot
    send_slot(1'b1, 16'hA5A5, 10);
    send_slot(1'b0, 16'h1234, 16);
    check_rx("R8 pre-lock");
    chk("R8 no error before lock", 32'(frame_err), 32'd0);

    // R2 R3: directed words
    send_frame(16'h8001, 16'h7FFE, 16, 16, 1);
    send_frame(16'hFFFF, 16'h0000, 16, 16, 1);
    send_frame(16'h0000, 16'hFFFF, 16, 16, 1);
    check_rx("R2 R3 directed");

    // R2 R3 R9: random words
    for (int k = 0; k < 16; k++)
      send_frame(16'($urandom), 16'($urandom), 16, 16, 1);
    check_rx("R3 random");

    // R4: 32-bit slots with random padding
    for (int k = 0; k < 3; k++)
      send_frame(16'($urandom), 16'($urandom), 32, 32, 1);
    check_rx("R4 wide slots");
    chk("R4 no error on wide slots", 32'(frame_err), 32'd0);

    // R5: short right slot, then a good frame
    send_frame(16'h1111, 16'h2222, 16, 9, 0);
    send_frame(16'h3333, 16'h4444, 16, 16, 1);
    check_rx("R5 short right");
    chk("R5 error set", 32'(frame_err), 32'd1);

    // R5 R6: short left slot, then a good frame
    send_frame(16'h5555, 16'h6666, 9, 16, 0);
    send_frame(16'h7777, 16'h8888, 16, 16, 1);
    check_rx("R6 short left");
    chk("R6 error sticky", 32'(frame_err), 32'd1);

    // R7: back-pressure, newer pair replaces unaccepted one
    lat_en = 1'b0;
    out_ready = 1'b0;
    send_frame(16'hAAAA, 16'hBBBB, 16, 16, 0);
    repeat (8) @(negedge clk);
    chk("R7 valid held", 32'(out_valid), 32'd1);
    chk("R7 held pair", {out_left, out_right}, 32'hAAAABBBB);
    send_frame(16'hCCCC, 16'hDDDD, 16, 16, 1);
    repeat (8) @(negedge clk);
    chk("R7 replaced pair", {out_left, out_right}, 32'hCCCCDDDD);
    repeat (20) @(negedge clk);
    chk("R7 still valid", 32'(out_valid), 32'd1);
    chk("R7 stable pair", {out_left, out_right}, 32'hCCCCDDDD);
    out_ready = 1'b1;
    check_rx("R7 handshake");
    chk("R7 consumed", 32'(out_valid), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule